// File: doc/BRIEF.md
# Encoded-Entry Direct Matcher

This block decides whether an incoming data word agrees with an entry that is kept in error-protected form, without decoding or repairing that entry first. It runs the incoming 33-bit word through the same systematic encoder that wrote the stored entry, which adds 7 check bits. It then XORs the resulting 40-bit codeword with the stored 40-bit codeword, data and check bits side by side. A tree of saturating adders counts the differing bits. The count decides the outcome.

The code corrects any single-bit error and detects any double-bit error. A stored entry with one flipped bit therefore still matches its data. Two differing bits raise a fault flag, because the entry cannot be repaired. Three or more differing bits mean a different word. The decision is registered. A request strobed on any cycle, including every cycle in a row, produces its result one clock later.

Top module: `ecc_direct_match`

## Requirements
- R1: Each cycle with `valid_i` high is followed, on the next cycle, by `done_o` high. Strobes on consecutive cycles give consecutive done pulses, and `done_o` is high only in the cycle after a strobe.
- R2: When the encoded incoming word equals the stored codeword (distance 0), the result is `match_o`=1 and `fault_o`=0.
- R3: When the encoded incoming word and the stored codeword differ in exactly one of the 40 bit positions, the result is `match_o`=1 and `fault_o`=0.
- R4: When they differ in exactly two positions, the result is `match_o`=0 and `fault_o`=1.
- R5: When they differ in three or more positions, the result is `match_o`=0 and `fault_o`=0.
- R6: `match_o` and `fault_o` are never high together.
- R7: In any cycle where `done_o` is low, `match_o` and `fault_o` are both low.
- R8: The codeword layout is data in bits [32:0] and check bits in bits [39:33]. Check bit j is the XOR of the data bits i whose column value c(i) has bit j set. c(i) is the i-th smallest 7-bit value with an odd number of ones and at least three ones.
- R9: An incoming word that differs from the stored entry's data is never reported as a match, and it is not reported as a fault when the stored entry itself is clean.
- R10: While reset is held, `done_o`, `match_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_i | input | 1 | Request strobe; the data and stored inputs are sampled while it is high |
| data_i | input | 33 | Incoming data word |
| stored_i | input | 40 | Stored codeword: data in [32:0], check bits in [39:33] |
| done_o | output | 1 | Result valid, one cycle after the strobe |
| match_o | output | 1 | The entry matches the incoming word (at most one bit differs) |
| fault_o | output | 1 | Two bits differ; the entry cannot be corrected |

## Verification
A wrong check-bit column in the encoder shows up on the first request that uses an affected data bit. A clean entry then lands at distance 1 or 2 instead of 0, and a singly flipped one moves up by one. Either way the wrong flag appears on the next cycle's done pulse. A saturating-adder node that loses its carry or saturates too early turns distance-2 or distance-3 results into false matches or false faults on that same pulse. A stuck done register shows within one cycle of a strobe, or of a gap between strobes. The scoreboard therefore checks every done pulse against a popcount it computes itself.

// File: rtl/ecm_pkg.sv
package ecm_pkg;

  // Column value for data bit idx: the idx-th smallest value of par_w bits
  // with odd weight of at least three.
  function automatic int unsigned col_value(input int idx, input int par_w);
    int found;
    int wt;
    col_value = 0;
    found = 0;
    for (int v = 0; v < (1 << par_w); v++) begin
      wt = 0;
      for (int b = 0; b < par_w; b++) wt += (v >> b) & 1;
      if ((wt % 2 == 1) && (wt >= 3)) begin
        if (found == idx) col_value = v;
        found++;
      end
    end
  endfunction

  // Selection mask of data bits feeding check bit row.
  function automatic logic [63:0] row_mask(input int row, input int data_w,
                                           input int par_w);
    row_mask = '0;
    for (int i = 0; i < data_w; i++)
      row_mask[i] = 1'((col_value(i, par_w) >> row) & 1);
  endfunction

  typedef enum logic [1:0] {
    DIST_ZERO = 2'd0,
    DIST_ONE  = 2'd1,
    DIST_TWO  = 2'd2,
    DIST_MANY = 2'd3
  } dist_e;

endpackage

// File: rtl/ecm_encoder.sv
module ecm_encoder #(
  parameter int DATA_W = 33,
  parameter int PAR_W  = 7
) (
  input  logic [DATA_W-1:0]       data_i,
  output logic [DATA_W+PAR_W-1:0] code_o
);
  logic [PAR_W-1:0] chk;

  for (genvar j = 0; j < PAR_W; j++) begin : g_row
    localparam logic [63:0] MASK_FULL = ecm_pkg::row_mask(j, DATA_W, PAR_W);
    localparam logic [DATA_W-1:0] MASK = MASK_FULL[DATA_W-1:0];
    assign chk[j] = ^(data_i & MASK);
  end

  assign code_o = {chk, data_i};
endmodule

// File: rtl/ecm_sat_add.sv
module ecm_sat_add #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  output logic [CNT_W-1:0] sum_o
);
  logic [CNT_W:0] raw;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    // carry out folds into the saturated code instead of a wider result
    sum_o = raw[CNT_W] ? {CNT_W{1'b1}} : raw[CNT_W-1:0];
  end
endmodule

// File: rtl/ecm_weight_acc.sv
module ecm_weight_acc #(
  parameter int N     = 40,
  parameter int CNT_W = 2
) (
  input  logic [N-1:0]     diff_i,
  output logic [CNT_W-1:0] weight_o
);
  localparam int DEPTH  = (N > 1) ? $clog2(N) : 1;
  localparam int LEAVES = 1 << DEPTH;
  localparam int NODES  = 2 * LEAVES - 1;

  logic [CNT_W-1:0] node [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_bit
      assign node[LEAVES-1+i] = CNT_W'(diff_i[i]);
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    ecm_sat_add #(.CNT_W(CNT_W)) u_add (
      .a_i   (node[2*k+1]),
      .b_i   (node[2*k+2]),
      .sum_o (node[k])
    );
  end

  assign weight_o = node[0];
endmodule

// File: rtl/ecc_direct_match.sv
module ecc_direct_match #(
  parameter int DATA_W = 33,
  parameter int PAR_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [DATA_W+PAR_W-1:0]   stored_i,
  output logic                      done_o,
  output logic                      match_o,
  output logic                      fault_o
);
  import ecm_pkg::*;

  localparam int CODE_W = DATA_W + PAR_W;
  localparam int CNT_W  = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [CODE_W-1:0] enc_code;
  logic [CODE_W-1:0] diff;
  logic [CNT_W-1:0]  weight;

  ecm_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_enc (
    .data_i (data_i),
    .code_o (enc_code)
  );

  // data and check bits are compared side by side in one vector
  assign diff = enc_code ^ stored_i;

  ecm_weight_acc #(.N(CODE_W), .CNT_W(CNT_W)) u_wacc (
    .diff_i   (diff),
    .weight_o (weight)
  );

  logic match_d, fault_d, done_d;
  logic match_q, fault_q, done_q;

  always_comb begin
    match_d = 1'b0;
    fault_d = 1'b0;
    done_d  = valid_i;
    if (valid_i) begin
      unique case (dist_e'(weight))
        DIST_ZERO, DIST_ONE: match_d = 1'b1;
        DIST_TWO:            fault_d = 1'b1;
        default:             ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      match_q <= match_d;
      fault_q <= fault_d;
    end
  end

  assign done_o  = done_q;
  assign match_o = match_q;
  assign fault_o = fault_q;

  // R1: a strobe yields done on the next cycle, and only then
  a_r1_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_i |=> done_o);
  a_r1_done_has_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_i |=> !done_o);
  // R6: match and fault are exclusive
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(match_o && fault_o));
  // R7: results are quiet outside done
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_o |-> (!match_o && !fault_o));
  // R5: the saturating tree agrees with an exact popcount of the difference
  a_r5_weight_saturates: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_i |-> (int'(weight) == (($countones(diff) > 3) ? 3 : $countones(diff))));
  // R4: two differing bits give a fault on the next cycle
  a_r4_two_is_fault: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && $countones(diff) == 2) |=> (fault_o && !match_o));

endmodule

// File: tb/ecc_direct_match_bench.sv
module ecc_direct_match_bench;
  localparam int DW = 33;
  localparam int PW = 7;
  localparam int CW = DW + PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [CW-1:0] stored_i = '0;
  logic          done_o, match_o, fault_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct packed { logic m; logic f; int d; } exp_t;
  exp_t sb [$];

  always #5 clk = ~clk;

  ecc_direct_match u_ecc_direct_match (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .data_i(data_i),
    .stored_i(stored_i), .done_o(done_o), .match_o(match_o), .fault_o(fault_o)
  );

  // R8 encoder, written from the requirement text
  function automatic logic [PW-1:0] ref_col(input int idx);
    int found = 0;
    ref_col = '0;
    for (int v = 0; v < 128; v++) begin
      if (($countones(7'(v)) % 2 == 1) && ($countones(7'(v)) >= 3)) begin
        if (found == idx) ref_col = 7'(v);
        found++;
      end
    end
  endfunction

  logic [PW-1:0] cols [DW];
  initial for (int i = 0; i < DW; i++) cols[i] = ref_col(i);

  function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
    logic [PW-1:0] p = '0;
    for (int i = 0; i < DW; i++) if (d[i]) p ^= cols[i];
    return {p, d};
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // driver: one request per call, expectation pushed to the scoreboard
  task automatic drive(input logic [DW-1:0] d, input logic [CW-1:0] s);
    exp_t e;
    e.d = $countones(ref_enc(d) ^ s);
    e.m = (e.d <= 1);
    e.f = (e.d == 2);
    data_i   = d;
    stored_i = s;
    valid_i  = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  function automatic logic [CW-1:0] flip(input logic [CW-1:0] w, input int n);
    logic [CW-1:0] m = '0;
    while ($countones(m) < n) m[$urandom_range(CW-1, 0)] = 1'b1;
    return w ^ m;
  endfunction

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && !finished) begin
        if (done_o) begin
          if (sb.size() == 0) begin
            check(1'b0, "R1", "done with no pending request (act done=1 exp 0)");
          end else begin
            e = sb.pop_front();
            check(match_o == e.m && fault_o == e.f,
                  (e.d == 0) ? "R2" : (e.d == 1) ? "R3" : (e.d == 2) ? "R4" : "R5",
                  $sformatf("dist %0d act m=%b f=%b exp m=%b f=%b",
                            e.d, match_o, fault_o, e.m, e.f));
            check(!(match_o && fault_o), "R6",
                  $sformatf("act m=%b f=%b exp not both", match_o, fault_o));
          end
        end else begin
          check(!match_o && !fault_o, "R7",
                $sformatf("idle act m=%b f=%b exp 0 0", match_o, fault_o));
        end
      end
    end
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: run hung (act running exp finished)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d, d2;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!done_o && !match_o && !fault_o, "R10",
          $sformatf("act d=%b m=%b f=%b exp 0 0 0", done_o, match_o, fault_o));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 known words, clean entries
    drive('0, ref_enc('0));
    drive('1, ref_enc('1));
    drive(33'h1, ref_enc(33'h1));
    drive(33'h1_0000_0000, ref_enc(33'h1_0000_0000));
    // R2..R5 random flips into the stored codeword, back to back
    for (int n = 0; n <= 3; n++) begin
      for (int k = 0; k < 40; k++) begin
        d = {$urandom(), 1'($urandom())};
        drive(d, flip(ref_enc(d), n));
      end
    end
    // flips at the check-bit end and at bit 0
    d = 33'h0_1234_5678;
    drive(d, ref_enc(d) ^ (40'h1 << 39));
    drive(d, ref_enc(d) ^ 40'h1);
    drive(d, ref_enc(d) ^ (40'h3 << 38));
    // R9 mismatched data against clean and flipped entries, with gaps
    for (int k = 0; k < 60; k++) begin
      d  = {$urandom(), 1'($urandom())};
      d2 = d ^ (33'h1 << $urandom_range(DW-1, 0));
      if (k % 3 == 0) d2 = d ^ {$urandom(), 1'($urandom())};
      if (d2 == d) d2 = ~d;
      drive(d2, flip(ref_enc(d), k % 2));
      if (k % 5 == 0) @(negedge clk);
    end
    // R9 direct check on a single-bit data mismatch with a clean entry
    d = 33'h0_0F0F_0F0F;
    drive(d ^ 33'h100, ref_enc(d));
    #1;
    check(!match_o && !fault_o && done_o, "R9",
          $sformatf("act d=%b m=%b f=%b exp 1 0 0", done_o, match_o, fault_o));
    repeat (3) @(negedge clk);
    // R1 no done without a strobe
    check(!done_o && sb.size() == 0, "R1",
          $sformatf("act done=%b pending=%0d exp 0 0", done_o, sb.size()));
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule